// File: doc/BRIEF.md
# Segmented-Paged Address Translator

This block turns a 32-bit logical address into a 32-bit physical address in two stages. The first stage reads a segment descriptor from an internal table. That table has one entry per segment number and is loaded through a configuration write port. The descriptor is checked for presence, size limit, privilege and access rights. The second stage reads one page entry from that segment's own page table in memory. It checks the entry and joins the entry's frame number with the page offset.

Requests arrive over a valid/ready handshake. Each request carries the logical address, an operation (read, write or execute) and the requester's privilege level. Every request gets exactly one response, which holds either a physical address or a 3-bit fault code.

Page entries are fetched over a memory port that allows one outstanding access. When a translation succeeds, the block sets the page entry's accessed flag, and for a write also its dirty flag. The updated entry is written back through the same port before the response is given. Several segment descriptors may name the same page table, so segments can share pages. Pages within one segment may sit in any frames at all.

Top module: `segpage_xlate`

## Requirements
- R1: The logical address is split as segment number = bits 31:24, page number = bits 23:14 and offset = bits 13:0, which gives a 16 KB page.
- R2: A cycle with `cfg_we_i` high loads the descriptor at `cfg_seg_i` at that clock edge. Requests accepted afterwards use the new descriptor. After reset every descriptor reads as not present.
- R3: A request to a segment whose present flag is clear responds with fault code 1 and makes no memory access.
- R4: The position {page, offset} is compared with the effective limit. With `cfg_gran_i` clear the limit is a byte limit; with it set the limit is multiplied by 16384. A position above the effective limit gives fault code 2. A position equal to the limit is allowed.
- R5: A request whose privilege level is numerically greater than the descriptor's level gives fault code 3.
- R6: Operation encoding is 0 read, 1 write, 2 execute, and 3 is handled as read. A write to a segment without write permission, or an execute from a segment without execute permission, gives fault code 3. Faults 1 to 3 respond two clock edges after acceptance with no memory access.
- R7: The page entry is read from the word at pt_base + page × 4. Its fields are bit 0 valid, bit 1 writable, bit 2 accessed, bit 3 dirty and bits 31:14 frame. A clear valid bit gives fault code 4.
- R8: A write to a page whose writable bit is clear gives fault code 5. Reads and executes ignore the writable bit, so a page can only narrow what the segment grants.
- R9: On success the fault code is 0 and the physical address is {frame, offset}.
- R10: On success the entry is written back to the same word with accessed set, and with dirty also set for a write. The write-back is skipped when those bits are already set. A faulting request writes nothing.
- R11: When several faults apply, the lowest code in the order 1, 2, 3, 4, 5 is reported.
- R12: `req_ready_o` is low from acceptance until the response is taken. The response stays valid and stable until `rsp_ready_i`. The physical address is zero on a fault.
- R13: The memory port has at most one access outstanding. A request holds its address, write flag and data until `mem_gnt_i`, and each access completes with one `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor load strobe |
| cfg_seg_i | input | 8 | Segment number to load |
| cfg_present_i | input | 1 | Descriptor present flag |
| cfg_gran_i | input | 1 | Limit counted in pages when set |
| cfg_limit_i | input | 24 | Segment limit |
| cfg_dpl_i | input | 2 | Descriptor privilege level |
| cfg_wr_ok_i | input | 1 | Segment allows writes |
| cfg_ex_ok_i | input | 1 | Segment allows execute |
| cfg_pt_base_i | input | 32 | Page table base address |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_va_i | input | 32 | Logical address |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 execute |
| req_cpl_i | input | 2 | Requester privilege level |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_pa_o | output | 32 | Physical address, zero on fault |
| rsp_fault_o | output | 3 | Fault code, 0 on success |
| mem_req_o | output | 1 | Memory access request |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Page entry byte address |
| mem_wdata_o | output | 32 | Updated page entry |
| mem_rvalid_i | input | 1 | Access complete, read data valid |
| mem_rdata_i | input | 32 | Page entry read data |

## Verification
A segment-level fault (codes 1 to 3) shows on the response exactly two rising edges after the request is accepted. The bench counts falling edges from acceptance and requires the response on the second one, with no memory grant. Page-level results follow the memory model's random grant and completion delays. The response comes one edge after the read completion, or one edge after the write-back completion when a write-back is needed. The bench therefore waits for `rsp_valid_o`, samples at the falling edge, and then checks the grant count and the page entry word held in memory.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
  localparam int unsigned SEG_W     = 8;
  localparam int unsigned PG_W      = 10;
  localparam int unsigned OFF_W     = 14;
  localparam int unsigned VA_W      = SEG_W + PG_W + OFF_W;
  localparam int unsigned PA_W      = 32;
  localparam int unsigned FRAME_W   = PA_W - OFF_W;
  localparam int unsigned LIM_W     = PG_W + OFF_W;
  localparam int unsigned PL_W      = 2;
  localparam int unsigned NSEG      = 1 << SEG_W;
  localparam int unsigned PTE_SHIFT = 2;
  localparam int unsigned POS_W     = LIM_W + OFF_W;

  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_W = 1;
  localparam int unsigned PTE_A = 2;
  localparam int unsigned PTE_D = 3;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EXEC  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    FLT_NONE       = 3'd0,
    FLT_SEG_ABSENT = 3'd1,
    FLT_SEG_LIMIT  = 3'd2,
    FLT_SEG_PROT   = 3'd3,
    FLT_PG_INVALID = 3'd4,
    FLT_PG_PROT    = 3'd5
  } fault_e;

  typedef struct packed {
    logic             present;
    logic             gran;
    logic [LIM_W-1:0] limit;
    logic [PL_W-1:0]  dpl;
    logic             wr_ok;
    logic             ex_ok;
    logic [PA_W-1:0]  pt_base;
  } seg_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_PT_REQ,
    ST_PT_WAIT,
    ST_WB_REQ,
    ST_WB_WAIT,
    ST_RSP
  } xl_state_e;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import segpage_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] widx_i,
  input  seg_desc_t        wdesc_i,
  input  logic [SEG_W-1:0] ridx_i,
  output seg_desc_t        rdesc_o
);
  seg_desc_t tbl_q [NSEG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSEG; i++) tbl_q[i] <= '0;
    end else if (we_i) begin
      tbl_q[widx_i] <= wdesc_i;
    end
  end

  assign rdesc_o = tbl_q[ridx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import segpage_pkg::*;
(
  input  seg_desc_t        desc_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [OFF_W-1:0] off_i,
  input  op_e              op_i,
  input  logic [PL_W-1:0]  cpl_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  pte_addr_o
);
  logic [POS_W-1:0] eff_lim;
  logic [POS_W-1:0] pos;
  logic             rights_bad;

  assign eff_lim = desc_i.gran ? {desc_i.limit, {OFF_W{1'b0}}}
                               : {{OFF_W{1'b0}}, desc_i.limit};
  assign pos     = {{OFF_W{1'b0}}, page_i, off_i};

  assign rights_bad = (cpl_i > desc_i.dpl)
                    | ((op_i == OP_WRITE) & ~desc_i.wr_ok)
                    | ((op_i == OP_EXEC)  & ~desc_i.ex_ok);

  // priority: absent > limit > privilege/rights
  always_comb begin
    if (!desc_i.present)     fault_o = FLT_SEG_ABSENT;
    else if (pos > eff_lim)  fault_o = FLT_SEG_LIMIT;
    else if (rights_bad)     fault_o = FLT_SEG_PROT;
    else                     fault_o = FLT_NONE;
  end

  assign pte_addr_o = desc_i.pt_base + PA_W'({page_i, {PTE_SHIFT{1'b0}}});
endmodule

// File: rtl/pte_check.sv
module pte_check
  import segpage_pkg::*;
(
  input  logic [PA_W-1:0]  pte_i,
  input  op_e              op_i,
  input  logic [OFF_W-1:0] off_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [PA_W-1:0]  pte_new_o,
  output logic             need_wb_o
);
  logic                  is_wr;
  logic [OFF_W-PTE_D-2:0] unused_pte_bits;

  assign is_wr           = (op_i == OP_WRITE);
  assign unused_pte_bits = pte_i[OFF_W-1:PTE_D+1];

  always_comb begin
    if (!pte_i[PTE_V])               fault_o = FLT_PG_INVALID;
    else if (is_wr && !pte_i[PTE_W]) fault_o = FLT_PG_PROT;
    else                             fault_o = FLT_NONE;
  end

  assign pa_o = {pte_i[PA_W-1:OFF_W], off_i};

  always_comb begin
    pte_new_o        = pte_i;
    pte_new_o[PTE_A] = 1'b1;
    if (is_wr) pte_new_o[PTE_D] = 1'b1;
  end

  assign need_wb_o = (pte_new_o != pte_i);
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import segpage_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SEG_W-1:0]   cfg_seg_i,
  input  logic               cfg_present_i,
  input  logic               cfg_gran_i,
  input  logic [LIM_W-1:0]   cfg_limit_i,
  input  logic [PL_W-1:0]    cfg_dpl_i,
  input  logic               cfg_wr_ok_i,
  input  logic               cfg_ex_ok_i,
  input  logic [PA_W-1:0]    cfg_pt_base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic [1:0]         req_op_i,
  input  logic [PL_W-1:0]    req_cpl_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [PA_W-1:0]    rsp_pa_o,
  output logic [2:0]         rsp_fault_o,
  output logic               mem_req_o,
  input  logic               mem_gnt_i,
  output logic               mem_we_o,
  output logic [PA_W-1:0]    mem_addr_o,
  output logic [PA_W-1:0]    mem_wdata_o,
  input  logic               mem_rvalid_i,
  input  logic [PA_W-1:0]    mem_rdata_i
);
  xl_state_e          state_q, state_d;
  logic [VA_W-1:0]    va_q;
  op_e                op_q;
  logic [PL_W-1:0]    cpl_q;
  logic [PA_W-1:0]    pte_addr_q, wb_data_q, pa_q;
  fault_e             fault_q;

  seg_desc_t          wdesc, rdesc;
  fault_e             seg_fault, pg_fault;
  logic [PA_W-1:0]    pte_addr, pg_pa, pte_new;
  logic               need_wb;

  logic [SEG_W-1:0]   va_seg;
  logic [PG_W-1:0]    va_page;
  logic [OFF_W-1:0]   va_off;

  assign va_seg  = va_q[VA_W-1 -: SEG_W];
  assign va_page = va_q[OFF_W +: PG_W];
  assign va_off  = va_q[OFF_W-1:0];

  assign wdesc = '{present: cfg_present_i, gran: cfg_gran_i, limit: cfg_limit_i,
                   dpl: cfg_dpl_i, wr_ok: cfg_wr_ok_i, ex_ok: cfg_ex_ok_i,
                   pt_base: cfg_pt_base_i};

  seg_table i_seg_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .widx_i  (cfg_seg_i),
    .wdesc_i (wdesc),
    .ridx_i  (va_seg),
    .rdesc_o (rdesc)
  );

  seg_check i_seg_check (
    .desc_i     (rdesc),
    .page_i     (va_page),
    .off_i      (va_off),
    .op_i       (op_q),
    .cpl_i      (cpl_q),
    .fault_o    (seg_fault),
    .pte_addr_o (pte_addr)
  );

  pte_check i_pte_check (
    .pte_i     (mem_rdata_i),
    .op_i      (op_q),
    .off_i     (va_off),
    .fault_o   (pg_fault),
    .pa_o      (pg_pa),
    .pte_new_o (pte_new),
    .need_wb_o (need_wb)
  );

  logic accept;
  assign accept = req_valid_i & (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_SEG;
      ST_SEG:     state_d = (seg_fault != FLT_NONE) ? ST_RSP : ST_PT_REQ;
      ST_PT_REQ:  if (mem_gnt_i) state_d = ST_PT_WAIT;
      ST_PT_WAIT: if (mem_rvalid_i) begin
                    if (pg_fault != FLT_NONE) state_d = ST_RSP;
                    else if (need_wb)         state_d = ST_WB_REQ;
                    else                      state_d = ST_RSP;
                  end
      ST_WB_REQ:  if (mem_gnt_i) state_d = ST_WB_WAIT;
      ST_WB_WAIT: if (mem_rvalid_i) state_d = ST_RSP;
      ST_RSP:     if (rsp_ready_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      op_q       <= OP_READ;
      cpl_q      <= '0;
      pte_addr_q <= '0;
      wb_data_q  <= '0;
      pa_q       <= '0;
      fault_q    <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (accept) begin
        va_q  <= req_va_i;
        op_q  <= (req_op_i == OP_RSVD) ? OP_READ : op_e'(req_op_i);
        cpl_q <= req_cpl_i;
      end
      if (state_q == ST_SEG) begin
        pte_addr_q <= pte_addr;
        fault_q    <= seg_fault;
        pa_q       <= '0;
      end
      if (state_q == ST_PT_WAIT && mem_rvalid_i) begin
        fault_q   <= pg_fault;
        pa_q      <= (pg_fault == FLT_NONE) ? pg_pa : '0;
        wb_data_q <= pte_new;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = fault_q;
  assign mem_req_o   = (state_q == ST_PT_REQ) | (state_q == ST_WB_REQ);
  assign mem_we_o    = (state_q == ST_WB_REQ);
  assign mem_addr_o  = pte_addr_q;
  assign mem_wdata_o = wb_data_q;
endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk
  import segpage_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [OFF_W-1:0] req_off_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [PA_W-1:0]  rsp_pa_o,
  input logic [2:0]       rsp_fault_o,
  input logic             mem_req_o,
  input logic             mem_gnt_i,
  input logic             mem_we_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic [PA_W-1:0]  mem_wdata_o,
  input logic             mem_rvalid_i
);
  logic [OFF_W-1:0] off_q;
  logic [1:0]       gnt_cnt_q;
  logic             outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= '0;
      gnt_cnt_q <= '0;
      outst_q   <= 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        off_q     <= req_off_i;
        gnt_cnt_q <= '0;
      end else if (mem_req_o && mem_gnt_i && gnt_cnt_q != 2'd3) begin
        gnt_cnt_q <= gnt_cnt_q + 2'd1;
      end
      if (mem_req_o && mem_gnt_i) outst_q <= 1'b1;
      else if (mem_rvalid_i)      outst_q <= 1'b0;
    end
  end

  a_r12_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o)));

  a_r12_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  a_r12_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> (rsp_pa_o == '0));

  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r13_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q |-> !mem_req_o);

  a_r9_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 3'd0) |-> (rsp_pa_o[OFF_W-1:0] == off_q));

  a_r6_seg_fault_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o >= 3'd1 && rsp_fault_o <= 3'd3) |-> (gnt_cnt_q == 2'd0));

  a_r10_wb_sets_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[PTE_A] && mem_wdata_o[PTE_V]));

  a_r11_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o <= 3'd5));
endmodule

bind segpage_xlate segpage_xlate_chk i_segpage_xlate_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_off_i    (req_va_i[13:0]),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_pa_o     (rsp_pa_o),
  .rsp_fault_o  (rsp_fault_o),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/test_segpage_xlate.sv
module test_segpage_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 0, cfg_present = 0, cfg_gran = 0, cfg_wr_ok = 0, cfg_ex_ok = 0;
  logic [7:0]  cfg_seg = 0;
  logic [23:0] cfg_limit = 0;
  logic [1:0]  cfg_dpl = 0;
  logic [31:0] cfg_pt_base = 0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_va = 0;
  logic [1:0]  req_op = 0, req_cpl = 0;
  logic        rsp_valid, rsp_ready = 0;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic        mem_req, mem_gnt = 0, mem_we, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  segpage_xlate i_segpage_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_seg_i(cfg_seg), .cfg_present_i(cfg_present),
    .cfg_gran_i(cfg_gran), .cfg_limit_i(cfg_limit), .cfg_dpl_i(cfg_dpl),
    .cfg_wr_ok_i(cfg_wr_ok), .cfg_ex_ok_i(cfg_ex_ok), .cfg_pt_base_i(cfg_pt_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_op_i(req_op), .req_cpl_i(req_cpl),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_pa_o(rsp_pa),
    .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  logic [31:0] mem [0:4095];
  logic        sh_p [256];
  logic        sh_g [256];
  logic [23:0] sh_lim [256];
  logic [1:0]  sh_dpl [256];
  logic        sh_w [256];
  logic        sh_x [256];
  logic [31:0] sh_ptb [256];
  int n_chk = 0, n_fail = 0, n_gnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory model: random grant and completion delays, one access at a time
  initial begin
    int stage = 0, dly = 0;
    logic [31:0] ma = 0, mwd = 0;
    logic mwe = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (stage == 0) begin
        if (mem_gnt) begin
          mem_gnt = 1'b0; stage = 1; dly = $urandom % 3;
        end else if (rst_n && mem_req && ($urandom % 4) != 0) begin
          mem_gnt = 1'b1; ma = mem_addr; mwe = mem_we; mwd = mem_wdata; n_gnt++;
        end
      end else if (dly == 0) begin
        if (mwe) mem[ma[13:2]] = mwd;
        mem_rdata = mem[ma[13:2]];
        mem_rvalid = 1'b1; stage = 0;
      end else dly--;
    end
  end

  task automatic cfg(input [7:0] idx, input p, input g, input [23:0] lim,
                     input [1:0] dpl, input w, input x, input [31:0] ptb);
    @(negedge clk);
    cfg_we = 1; cfg_seg = idx; cfg_present = p; cfg_gran = g; cfg_limit = lim;
    cfg_dpl = dpl; cfg_wr_ok = w; cfg_ex_ok = x; cfg_pt_base = ptb;
    sh_p[idx] = p; sh_g[idx] = g; sh_lim[idx] = lim; sh_dpl[idx] = dpl;
    sh_w[idx] = w; sh_x[idx] = x; sh_ptb[idx] = ptb;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic void model(input [31:0] va, input [1:0] op, input [1:0] cpl,
      output [2:0] f, output [31:0] pa, output [11:0] wi, output [31:0] np,
      output int ng);
    logic [7:0]  s = va[31:24];
    logic [9:0]  pg = va[23:14];
    logic [13:0] off = va[13:0];
    logic [37:0] eff, pos;
    logic [31:0] pta, pte;
    f = 0; pa = 0; wi = 0; np = 0; ng = 0;
    eff = sh_g[s] ? {sh_lim[s], 14'b0} : {14'b0, sh_lim[s]};
    pos = {14'b0, pg, off};
    if (!sh_p[s]) f = 1;
    else if (pos > eff) f = 2;
    else if (cpl > sh_dpl[s] || (op == 1 && !sh_w[s]) || (op == 2 && !sh_x[s])) f = 3;
    else begin
      pta = sh_ptb[s] + {20'b0, pg, 2'b00};
      wi = pta[13:2]; pte = mem[wi]; ng = 1; np = pte;
      if (!pte[0]) f = 4;
      else if (op == 1 && !pte[1]) f = 5;
      else begin
        pa = {pte[31:14], off};
        np = pte | 32'h4 | ((op == 1) ? 32'h8 : 32'h0);
        if (np != pte) ng = 2;
      end
    end
  endfunction

  task automatic xreq(input [31:0] va, input [1:0] op, input [1:0] cpl,
                      input int hold, input string tag);
    logic [2:0] ef; logic [31:0] epa, enp, hpa; logic [11:0] wi; int eng, g0, n;
    logic [2:0] hf; bit stable_ok = 1;
    model(va, op, cpl, ef, epa, wi, enp, eng);
    g0 = n_gnt;
    @(negedge clk);
    req_valid = 1; req_va = va; req_op = op; req_cpl = cpl;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    chk(rsp_fault == ef, tag, "fault", {29'b0, rsp_fault}, {29'b0, ef});
    chk(rsp_pa == epa, tag, "pa", rsp_pa, epa);
    if (ef >= 1 && ef <= 3)
      chk(n == 2, "R6", "segment fault latency", n, 2);
    hpa = rsp_pa; hf = rsp_fault;
    if (hold > 0) begin
      repeat (hold) begin
        @(negedge clk);
        if (!rsp_valid || rsp_pa != hpa || rsp_fault != hf) stable_ok = 0;
      end
      chk(stable_ok, "R12", "response held", {31'b0, stable_ok}, 1);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R12", "single response",
        {30'b0, rsp_valid, req_ready}, 32'h1);
    chk(n_gnt - g0 == eng, (ef >= 1 && ef <= 3) ? "R3" : "R10", "memory grants",
        n_gnt - g0, eng);
    if (eng > 0) chk(mem[wi] == enp, "R10", "page entry after", mem[wi], enp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5e9a_0c21));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    for (int i = 0; i < 256; i++) begin
      sh_p[i] = 0; sh_g[i] = 0; sh_lim[i] = 0; sh_dpl[i] = 0;
      sh_w[i] = 0; sh_x[i] = 0; sh_ptb[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(req_ready && !rsp_valid && !mem_req, "R2", "reset outputs",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    xreq(32'h0200_0000, 0, 0, 0, "R2");  // table empty after reset -> code 1

    cfg(8'd2, 1, 0, 24'h00_5FFF, 2'd3, 1, 0, 32'h1000);
    cfg(8'd3, 1, 1, 24'd4,       2'd0, 0, 1, 32'h2000);
    cfg(8'd7, 1, 1, 24'd1023,    2'd3, 1, 1, 32'h1000);

    // R7/R9 page entry setup: seg2 page1 -> word 0x401
    mem[12'h401] = {18'h2_A5A5, 10'b0, 4'b0011};
    xreq({8'd2, 10'd1, 14'h1FFF}, 0, 3, 0, "R4");   // at byte limit
    xreq({8'd2, 10'd1, 14'h2000}, 0, 3, 0, "R4");   // one past limit
    xreq({8'd2, 10'd1, 14'h2000}, 2, 3, 0, "R11");  // limit beats rights
    xreq({8'd3, 10'd4, 14'h0000}, 2, 0, 0, "R4");   // page-granular limit edge
    xreq({8'd3, 10'd4, 14'h0001}, 2, 0, 0, "R4");
    xreq({8'd3, 10'd0, 14'h0010}, 2, 1, 0, "R5");
    xreq({8'd3, 10'd0, 14'h0010}, 1, 0, 0, "R6");
    xreq({8'd2, 10'd0, 14'h0010}, 2, 3, 0, "R6");
    xreq({8'd9, 10'd1, 14'h3FFF}, 1, 3, 0, "R11");  // absent beats limit
    // R8 read-only page
    mem[12'h402] = {18'h0_1234, 10'b0, 4'b0001};
    xreq({8'd2, 10'd2, 14'h0004}, 1, 3, 0, "R8");
    xreq({8'd7, 10'd2, 14'h0004}, 2, 3, 0, "R8");   // exec ignores writable
    mem[12'h403] = {18'h0_0777, 10'b0, 4'b0000};
    xreq({8'd7, 10'd3, 14'h0008}, 1, 3, 0, "R11");  // invalid beats protection
    xreq({8'd7, 10'd3, 14'h0008}, 0, 3, 0, "R7");
    // R10 write sets dirty, then shared segment sees same entry, no second write-back
    xreq({8'd2, 10'd1, 14'h0ABC}, 1, 3, 2, "R10");
    xreq({8'd7, 10'd1, 14'h0ABC}, 0, 3, 0, "R9");
    xreq({8'd7, 10'd1, 14'h0ABC}, 3, 3, 3, "R6");   // op 3 handled as read
    xreq({8'd2, 10'd1, 14'h0000}, 1, 3, 0, "R1");
    // R2 descriptor overwrite
    cfg(8'd2, 0, 0, 24'h00_5FFF, 2'd3, 1, 0, 32'h1000);
    xreq({8'd2, 10'd1, 14'h0ABC}, 0, 3, 0, "R2");
    cfg(8'd2, 1, 0, 24'h00_5FFF, 2'd3, 1, 0, 32'h1000);

    for (int k = 0; k < 300; k++) begin
      logic [7:0] s; logic [9:0] pg; logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: s = 8'd2;
        2'd1: s = 8'd3;
        2'd2: s = 8'd7;
        default: s = 8'd9;
      endcase
      pg = r[2] ? 10'($urandom % 6) : 10'($urandom);
      xreq({s, pg, 14'($urandom)}, 2'($urandom), 2'($urandom),
           int'($urandom % 3), "R13");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule